// File: doc/BRIEF.md
# Dual-Source Memory Request Arbiter

This block lets two clients share one simple SRAM-style memory port. One client is a stream loader. It writes 16-bit audio words and flags the first word of each new file. The other client is a playback engine. It reads words back by address and tags each read with a slot number. Each client raises a strobe, and the strobe may stay high for many cycles, as happens when the client runs on a slower clock. The block turns each rising edge of a strobe into one tagged 32-bit request word and places it in an internal queue.

A separate service machine takes requests from the queue one at a time. It drives the memory address, write data, read enable and write enable, and holds them for a fixed number of cycles. It then reports the result. A finished write reports the address that was written and its new-file flag. A finished read reports the returned data and the slot number of the request. Write addresses are not carried in the requests. They come from an internal counter that starts at zero, so files are laid down one after another from the bottom of memory.

Top module: `ram_req_arbiter`

## Requirements
- R1: After reset, `mem_re`, `mem_we`, `wr_done`, `rd_done` are low and `q_level` is zero.
- R2: A read request drives `mem_addr` equal to the `pb_addr` captured at the strobe edge. At the end of the hold, `rd_done` reports the `mem_rdata` value and the captured `pb_slot`. A read is queued as a word whose bits [31:30] are 2'b10, [29:25] the slot and [24:0] the address.
- R3: A write request drives `mem_wdata` equal to the captured `ld_data`. `mem_addr` comes from a counter that starts at 0 and increments by one after each write. `wr_done` reports that address and the captured `ld_new_file`. A write is queued as a word whose bits [31:30] are 2'b11, bit [29] the new-file flag and [15:0] the data.
- R4: Each low-to-high transition of a strobe queues exactly one request, however many cycles the strobe stays high.
- R5: When both strobes rise in the same cycle, both requests are served and none is lost. The write is queued first.
- R6: Each access keeps its enable high for exactly `HOLD_CYCLES` consecutive cycles. `mem_addr` and `mem_wdata` stay stable during that time, and `mem_re` and `mem_we` are never high together.
- R7: Requests are served in the order they were queued.
- R8: `q_level` equals the number of requests queued but not yet taken by the service machine.
- R9: With the queue empty, no access starts and both enables stay low.
- R10: `wr_done` or `rd_done` is a single-cycle pulse. It comes in the first cycle after the enable of the finished access drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_strobe | input | 1 | Loader request strobe (level, edge-detected) |
| ld_new_file | input | 1 | Marks the loader word as the first of a file |
| ld_data | input | 16 | Loader write data |
| pb_strobe | input | 1 | Playback request strobe (level, edge-detected) |
| pb_slot | input | 5 | Playback slot tag |
| pb_addr | input | 25 | Playback read address |
| mem_addr | output | 25 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| wr_done | output | 1 | Write completed pulse |
| wr_done_addr | output | 25 | Address of the completed write |
| wr_done_new | output | 1 | New-file flag of the completed write |
| rd_done | output | 1 | Read completed pulse |
| rd_done_data | output | 16 | Data returned by the completed read |
| rd_done_slot | output | 5 | Slot tag of the completed read |
| q_level | output | $clog2(QUEUE_DEPTH)+1 | Number of queued requests |

## Verification
Two things can land in the same clock edge. A strobe edge can push a request into the queue while the service machine pops the head. Both strobes can also rise together, so that two requests compete for the single push path. Random traffic with gaps from zero cycles upward often pushes while the service machine pops. Directed cases raise both strobes on one edge, and they fill the queue with a burst while an access is in flight. Every access and every completion is compared in order against a bench scoreboard and a shadow memory. The occupancy is compared against a count worked out from the number of edges and pops.

// File: rtl/ram_req_arbiter.sv
module ram_req_arbiter #(
  parameter int QUEUE_DEPTH = 1024,
  parameter int HOLD_CYCLES = 21
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_strobe,
  input  logic                          ld_new_file,
  input  logic [15:0]                   ld_data,
  input  logic                          pb_strobe,
  input  logic [4:0]                    pb_slot,
  input  logic [24:0]                   pb_addr,
  output logic [24:0]                   mem_addr,
  output logic [15:0]                   mem_wdata,
  input  logic [15:0]                   mem_rdata,
  output logic                          mem_re,
  output logic                          mem_we,
  output logic                          wr_done,
  output logic [24:0]                   wr_done_addr,
  output logic                          wr_done_new,
  output logic                          rd_done,
  output logic [15:0]                   rd_done_data,
  output logic [4:0]                    rd_done_slot,
  output logic [$clog2(QUEUE_DEPTH):0]  q_level
);

  localparam int PW = $clog2(QUEUE_DEPTH);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [PW:0] FULL_LVL = (PW+1)'(QUEUE_DEPTH);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

  // request capture
  logic        ld_prev, pb_prev, ld_pend, pb_pend;
  logic [31:0] ld_word, pb_word;

  wire ld_rise = ld_strobe & ~ld_prev;
  wire pb_rise = pb_strobe & ~pb_prev;
  wire do_push = (ld_pend | pb_pend) && (q_level < FULL_LVL);
  wire [31:0] push_word = ld_pend ? ld_word : pb_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_prev <= 1'b0;
      pb_prev <= 1'b0;
      ld_pend <= 1'b0;
      pb_pend <= 1'b0;
      ld_word <= '0;
      pb_word <= '0;
    end else begin
      ld_prev <= ld_strobe;
      pb_prev <= pb_strobe;
      if (ld_rise) begin
        ld_pend <= 1'b1;
        ld_word <= {2'b11, ld_new_file, 13'd0, ld_data};
      end else if (do_push && ld_pend) begin
        ld_pend <= 1'b0;
      end
      if (pb_rise) begin
        pb_pend <= 1'b1;
        pb_word <= {2'b10, pb_slot, pb_addr};
      end else if (do_push && !ld_pend) begin
        pb_pend <= 1'b0;
      end
    end
  end

  // request queue
  logic [31:0]   qmem [QUEUE_DEPTH];
  logic [PW-1:0] head, tail;
  logic          busy;
  wire           do_pop = !busy && (q_level != '0);
  wire [31:0]    head_word = qmem[head];

  always_ff @(posedge clk) begin
    if (do_push) qmem[tail] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      q_level <= '0;
    end else begin
      if (do_push) tail <= (tail == PW'(QUEUE_DEPTH - 1)) ? '0 : tail + 1'b1;
      if (do_pop)  head <= (head == PW'(QUEUE_DEPTH - 1)) ? '0 : head + 1'b1;
      q_level <= q_level + (PW+1)'(do_push) - (PW+1)'(do_pop);
    end
  end

  // service machine
  logic [CW-1:0] hold;
  logic [24:0]   wr_ptr;
  logic          cur_new;
  logic [4:0]    cur_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      hold         <= '0;
      wr_ptr       <= '0;
      cur_new      <= 1'b0;
      cur_slot     <= '0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_re       <= 1'b0;
      mem_we       <= 1'b0;
      wr_done      <= 1'b0;
      wr_done_addr <= '0;
      wr_done_new  <= 1'b0;
      rd_done      <= 1'b0;
      rd_done_data <= '0;
      rd_done_slot <= '0;
    end else begin
      wr_done <= 1'b0;
      rd_done <= 1'b0;
      if (do_pop) begin
        busy      <= 1'b1;
        hold      <= HOLD_LAST;
        mem_we    <= head_word[31:30] == 2'b11;
        mem_re    <= head_word[31:30] == 2'b10;
        mem_addr  <= (head_word[31:30] == 2'b11) ? wr_ptr : head_word[24:0];
        mem_wdata <= (head_word[31:30] == 2'b11) ? head_word[15:0] : 16'd0;
        cur_new   <= head_word[29];
        cur_slot  <= head_word[29:25];
      end else if (busy) begin
        if (hold == '0) begin
          busy   <= 1'b0;
          mem_re <= 1'b0;
          mem_we <= 1'b0;
          if (mem_we) begin
            wr_done      <= 1'b1;
            wr_done_addr <= mem_addr;
            wr_done_new  <= cur_new;
            wr_ptr       <= wr_ptr + 1'b1;
          end
          if (mem_re) begin
            rd_done      <= 1'b1;
            rd_done_data <= mem_rdata;
            rd_done_slot <= cur_slot;
          end
        end else begin
          hold <= hold - 1'b1;
        end
      end
    end
  end

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we));

  p_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_re || mem_we) && $past(mem_re || mem_we)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  p_wdone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> ($past(mem_we) && !mem_we && !rd_done));

  p_rdone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> ($past(mem_re) && !mem_re));

  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_re || mem_we) |-> $past(q_level != '0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n) q_level <= FULL_LVL);

endmodule

// File: tb/ram_req_arbiter_bench.sv
module ram_req_arbiter_bench;
  localparam int HOLD = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_strobe = 1'b0, ld_new_file = 1'b0, pb_strobe = 1'b0;
  logic [15:0] ld_data = '0;
  logic [4:0]  pb_slot = '0;
  logic [24:0] pb_addr = '0;
  logic [24:0] mem_addr, wr_done_addr;
  logic [15:0] mem_wdata, rd_done_data;
  logic [15:0] mem_rdata;
  logic mem_re, mem_we, wr_done, wr_done_new, rd_done;
  logic [4:0] rd_done_slot;
  logic [10:0] q_level;

  always #10 clk = ~clk;

  ram_req_arbiter #(.QUEUE_DEPTH(1024), .HOLD_CYCLES(HOLD)) u_ram_req_arbiter (
    .clk(clk), .rst_n(rst_n),
    .ld_strobe(ld_strobe), .ld_new_file(ld_new_file), .ld_data(ld_data),
    .pb_strobe(pb_strobe), .pb_slot(pb_slot), .pb_addr(pb_addr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_we(mem_we),
    .wr_done(wr_done), .wr_done_addr(wr_done_addr), .wr_done_new(wr_done_new),
    .rd_done(rd_done), .rd_done_data(rd_done_data), .rd_done_slot(rd_done_slot),
    .q_level(q_level));

  function automatic logic [15:0] seed_word(int i);
    return 16'(i * 16'h3b1 ^ 16'h5a0f);
  endfunction

  logic [15:0] ram [256];
  logic [15:0] shadow [256];
  initial for (int i = 0; i < 256; i++) begin ram[i] = seed_word(i); shadow[i] = seed_word(i); end

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  typedef struct packed {
    logic        is_wr;
    logic [24:0] a;
    logic [15:0] d;
    logic        nf;
    logic [4:0]  id;
  } exp_t;
  exp_t expq[$];

  int tests = 0, fails = 0;
  logic [24:0] wr_count = '0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t make_wr(logic nf, logic [15:0] d);
    exp_t e;
    e = '0; e.is_wr = 1'b1; e.a = wr_count; e.d = d; e.nf = nf;
    return e;
  endfunction

  function automatic exp_t make_rd(logic [4:0] id, logic [24:0] a);
    exp_t e;
    e = '0; e.a = a; e.id = id; e.d = shadow[a[7:0]];
    return e;
  endfunction

  task automatic issue(bit w, bit r, int len, logic nf, logic [15:0] d, logic [4:0] id, logic [24:0] a);
    @(negedge clk);
    if (w) begin
      ld_new_file = nf; ld_data = d; ld_strobe = 1'b1;
      expq.push_back(make_wr(nf, d));
      shadow[wr_count[7:0]] = d;
      wr_count = wr_count + 1'b1;
    end
    if (r) begin
      pb_slot = id; pb_addr = a; pb_strobe = 1'b1;
      expq.push_back(make_rd(id, a));
    end
    repeat (len) @(negedge clk);
    ld_strobe = 1'b0; pb_strobe = 1'b0;
  endtask

  // monitor
  bit prev_act = 1'b0;
  int hold_len = 0;
  logic [24:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (mem_re && mem_we) chk(1'b0, "R6 both enables", 32'd1, 32'd0);
      if ((mem_re || mem_we) && !prev_act) begin
        hold_len = 1;
        if (expq.size() == 0) chk(1'b0, "R9 access with empty queue", mem_addr, 32'd0);
        else if (expq[0].is_wr) begin
          chk(mem_we, "R3 write enable", {31'd0, mem_we}, 32'd1);
          chk(mem_addr == expq[0].a, "R3 write addr", mem_addr, expq[0].a);
          chk(mem_wdata == expq[0].d, "R3 write data", mem_wdata, expq[0].d);
        end else begin
          chk(mem_re, "R7 read in order", {31'd0, mem_re}, 32'd1);
          chk(mem_addr == expq[0].a, "R2 read addr", mem_addr, expq[0].a);
        end
      end else if (mem_re || mem_we) begin
        hold_len++;
        if (mem_addr != prev_addr) chk(1'b0, "R6 addr stable", mem_addr, prev_addr);
      end else if (prev_act) begin
        chk(hold_len == HOLD, "R6 hold length", hold_len, HOLD);
      end
      if (wr_done || rd_done) begin
        chk(!mem_re && !mem_we && !(wr_done && rd_done), "R10 done after enable drops",
            {mem_re, mem_we}, 32'd0);
        if (expq.size() == 0) chk(1'b0, "R4 extra completion", 32'd1, 32'd0);
        else begin
          if (wr_done) begin
            chk(expq[0].is_wr, "R7 write completion order", 32'd1, {31'd0, expq[0].is_wr});
            chk(wr_done_addr == expq[0].a, "R3 done addr", wr_done_addr, expq[0].a);
            chk(wr_done_new == expq[0].nf, "R3 done new-file", wr_done_new, expq[0].nf);
          end else begin
            chk(!expq[0].is_wr, "R7 read completion order", 32'd0, {31'd0, expq[0].is_wr});
            chk(rd_done_data == expq[0].d, "R2 read data", rd_done_data, expq[0].d);
            chk(rd_done_slot == expq[0].id, "R2 read slot", rd_done_slot, expq[0].id);
          end
          void'(expq.pop_front());
        end
      end
      prev_act = mem_re || mem_we;
      prev_addr = mem_addr;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!mem_re && !mem_we && !wr_done && !rd_done && q_level == 0, "R1 reset state",
        {mem_re, mem_we, wr_done, rd_done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 burst: 4 one-cycle pulses; first popped, three waiting
    for (int i = 0; i < 4; i++) issue(1'b1, 1'b0, 1, i == 0, 16'h1000 + 16'(i), 5'd0, 25'd0);
    repeat (3) @(negedge clk);
    chk(q_level == 3, "R8 occupancy", q_level, 32'd3);
    drain();
    chk(q_level == 0, "R8 drained occupancy", q_level, 32'd0);

    // R4 long strobes
    issue(1'b1, 1'b0, 12, 1'b1, 16'hbeef, 5'd0, 25'd0);
    issue(1'b0, 1'b1, 9, 1'b0, 16'd0, 5'd29, 25'd1);
    repeat (4) @(negedge clk);
    chk(q_level == 0, "R4 single entry per long strobe", q_level, 32'd0);
    drain();

    // R5 simultaneous, read of word just written
    issue(1'b1, 1'b1, 2, 1'b0, 16'h7e57, 5'd17, wr_count);
    drain();
    issue(1'b1, 1'b1, 1, 1'b1, 16'h0042, 5'd3, 25'd200);
    drain();

    // R9 idle
    repeat (60) @(negedge clk);
    chk(!mem_re && !mem_we, "R9 idle enables", {mem_re, mem_we}, 32'd0);

    // random traffic
    for (int n = 0; n < 220; n++) begin
      int k = int'($urandom_range(2, 0));
      issue(k != 1, k != 0, int'($urandom_range(4, 1)), 1'($urandom_range(1, 0)),
            16'($urandom), 5'($urandom_range(29, 0)), 25'($urandom_range(255, 0)));
      repeat ($urandom_range(30, 0)) @(negedge clk);
    end
    drain();
    chk(expq.size() == 0 && q_level == 0, "R7 all served", q_level, 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule